// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block owns the control word of a clock synthesizer: a 9-bit feedback divider value, a 2-bit output divider code and a spread-spectrum enable bit. It offers two ways to program that word. The parallel path uses nine divider pins and an active-low load strobe. The serial path uses a three-wire port made of a clock, a data line and a load strobe, and it fills a shift register. The outputs carry the values that the downstream dividers currently use.

All four strobe and serial lines pass through synchronizers into a faster system clock. Edges are found in that clock domain. The parallel path has priority. While the parallel strobe is low, the divider pins flow straight through and the output divider is forced to divide by two. Once the strobe rises, the last pin value is kept until a serial load replaces it or the strobe falls again.

The serial load strobe works in two ways. A rising edge copies the shift register to the outputs, and a falling edge freezes them. While the strobe stays high, the outputs follow the shift register after every serial clock edge. A range flag marks feedback values outside the band where the loop can lock. A one-cycle pulse reports every change of the active word, so downstream counters can reload.

Top module: `synth_cfg_loader`

## Requirements
- R1: While `rst_n` is low, `out_div_code` becomes 01, `spread_en` becomes 0, the shift register clears, `cfg_update` stays 0 and `fb_div` takes the value on `fb_div_pin`.
- R2: While the synchronized `par_load_n` is low, `fb_div` follows `fb_div_pin` and `out_div_code` is forced to 01 (divide by two). `spread_en` keeps its value.
- R3: After `par_load_n` rises, `fb_div` keeps the last pin value, and later changes on `fb_div_pin` have no effect on it.
- R4: While `par_load_n` is high, each rising edge of `ser_clk` shifts `ser_dat` into the register. The frame is 14 bits long and is sent in this time order: two ignored bits, the spread bit, code bit 1, code bit 0, then divider bits 8 down to 0. A rising edge of `ser_ld` copies the register to `spread_en`, `out_div_code` and `fb_div`.
- R5: When `ser_ld` is low and `par_load_n` is high, the outputs hold their values. Shifting does not change them, and the falling edge of `ser_ld` leaves the loaded value in place.
- R6: While `ser_ld` stays high and `par_load_n` is high, each rising edge of `ser_clk` puts the newly shifted register contents on the outputs.
- R7: While `par_load_n` is low, serial clock, data and load activity has no effect on the outputs.
- R8: `fb_div_bad` is 1 exactly when `fb_div` is below 125 or above 350.
- R9: `cfg_update` pulses for one cycle in the cycle that any of `fb_div`, `out_div_code` or `spread_en` takes a new value. It stays low otherwise.
- R10: A serially loaded word stays in effect until `par_load_n` goes low again. At that point the pin value and the divide-by-two code take over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all programming lines |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_div_pin | input | 9 | Parallel feedback divider value |
| par_load_n | input | 1 | Parallel load strobe, active low |
| ser_clk | input | 1 | Serial programming clock |
| ser_dat | input | 1 | Serial programming data |
| ser_ld | input | 1 | Serial load strobe |
| fb_div | output | 9 | Active feedback divider value |
| out_div_code | output | 2 | Active output divider code (00 /1, 01 /2, 10 /4, 11 /8) |
| spread_en | output | 1 | Active spread-spectrum enable |
| fb_div_bad | output | 1 | Feedback value outside the lockable band |
| cfg_update | output | 1 | One-cycle pulse when the active word changes |

## Verification
The bench targets the following errors and the symptom each would show:
- Frame order and bit position: if the bit order or the number of ignored slots is wrong, the spread and code fields are swapped or shifted into the divider. Random frames expose this.
- Serial strobe: a design that treats the strobe as a level would change the outputs while bits are still being shifted. A design that misses transparent mode would hold the outputs while the strobe is high.
- Parallel priority: if the parallel path does not win, a serial load strobed during parallel mode would replace the pin value.
- Range flag: the flag is checked at 124, 125, 350 and 351, which catches an off-by-one bound.
- Update pulse: its count per operation is compared against whether the word really changed. This catches missing pulses and spurious ones.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
   localparam int DEF_M_W   = 9;
   localparam int DEF_N_W   = 2;
   localparam int DEF_NULLS = 2;

   function automatic int word_bits(input int n_w, input int m_w);
      return 1 + n_w + m_w;
   endfunction
endpackage

// File: rtl/cfg_sync_bank.sv
module cfg_sync_bank #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise
);
   logic [WIDTH-1:0] prev_q;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], din[b]};
      end
      assign lvl[b] = chain_q[STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
   parameter int SR_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shift_en,
   input  logic            bit_in,
   output logic [SR_W-1:0] sr_q,
   output logic [SR_W-1:0] sr_nxt
);
   assign sr_nxt = {sr_q[SR_W-2:0], bit_in};

   always_ff @(posedge clk) begin
      if (!rst_n)        sr_q <= '0;
      else if (shift_en) sr_q <= sr_nxt;
   end
endmodule

// File: rtl/cfg_hold_unit.sv
module cfg_hold_unit #(
   parameter int             M_W   = 9,
   parameter int             N_W   = 2,
   parameter logic [N_W-1:0] N_RST = 'b01,
   parameter logic [N_W-1:0] N_PAR = 'b01,
   localparam int            SR_W  = 1 + N_W + M_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [M_W-1:0]  pin_m,
   input  logic            par_hi,
   input  logic            ld_hi,
   input  logic            ld_rise,
   input  logic            sck_rise,
   input  logic [SR_W-1:0] sr_cur,
   input  logic [SR_W-1:0] sr_nxt,
   output logic [M_W-1:0]  m_q,
   output logic [N_W-1:0]  n_q,
   output logic            ssc_q,
   output logic            upd_q
);
   logic [M_W-1:0] m_d;
   logic [N_W-1:0] n_d;
   logic           ssc_d;

   always_comb begin
      m_d   = m_q;
      n_d   = n_q;
      ssc_d = ssc_q;
      if (!par_hi) begin
         m_d = pin_m;
         n_d = N_PAR;
      end else if (ld_rise) begin
         {ssc_d, n_d, m_d} = sr_cur;
      end else if (ld_hi && sck_rise) begin
         {ssc_d, n_d, m_d} = sr_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_q   <= pin_m;
         n_q   <= N_RST;
         ssc_q <= 1'b0;
         upd_q <= 1'b0;
      end else begin
         m_q   <= m_d;
         n_q   <= n_d;
         ssc_q <= ssc_d;
         upd_q <= (m_d != m_q) || (n_d != n_q) || (ssc_d != ssc_q);
      end
   end
endmodule

// File: rtl/cfg_range_chk.sv
module cfg_range_chk #(
   parameter int M_W  = 9,
   parameter int M_LO = 125,
   parameter int M_HI = 350
) (
   input  logic [M_W-1:0] m,
   output logic           bad
);
   localparam logic [M_W-1:0] LO_V = M_W'(M_LO);
   localparam logic [M_W-1:0] HI_V = M_W'(M_HI);
   assign bad = (m < LO_V) || (m > HI_V);
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
   import cfg_loader_pkg::*;
#(
   parameter int             M_W         = DEF_M_W,
   parameter int             N_W         = DEF_N_W,
   parameter int             SYNC_STAGES = 2,
   parameter int             M_LO        = 125,
   parameter int             M_HI        = 350,
   parameter logic [N_W-1:0] N_RST       = 'b01,
   parameter logic [N_W-1:0] N_PAR       = 'b01
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [M_W-1:0] fb_div_pin,
   input  logic           par_load_n,
   input  logic           ser_clk,
   input  logic           ser_dat,
   input  logic           ser_ld,
   output logic [M_W-1:0] fb_div,
   output logic [N_W-1:0] out_div_code,
   output logic           spread_en,
   output logic           fb_div_bad,
   output logic           cfg_update
);
   localparam int SR_W = word_bits(N_W, M_W);
   localparam int L_SCK = 0, L_DAT = 1, L_LD = 2, L_PAR = 3;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (M_LO > M_HI || M_HI >= (1 << M_W)) begin : g_bad_range
      $error("lock range does not fit the divider width");
   end

   logic [3:0]      sync_lvl, sync_rise;
   logic [SR_W-1:0] sr_q, sr_nxt;
   logic            pl_hi_s, ld_s;

   cfg_sync_bank #(.WIDTH(4), .STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({par_load_n, ser_ld, ser_dat, ser_clk}),
      .lvl  (sync_lvl),
      .rise (sync_rise)
   );

   assign pl_hi_s = sync_lvl[L_PAR];
   assign ld_s    = sync_lvl[L_LD];

   cfg_shift_reg #(.SR_W(SR_W)) shift_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(sync_rise[L_SCK] & pl_hi_s),
      .bit_in  (sync_lvl[L_DAT]),
      .sr_q    (sr_q),
      .sr_nxt  (sr_nxt)
   );

   cfg_hold_unit #(.M_W(M_W), .N_W(N_W), .N_RST(N_RST), .N_PAR(N_PAR)) hold_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_m   (fb_div_pin),
      .par_hi  (pl_hi_s),
      .ld_hi   (ld_s),
      .ld_rise (sync_rise[L_LD]),
      .sck_rise(sync_rise[L_SCK]),
      .sr_cur  (sr_q),
      .sr_nxt  (sr_nxt),
      .m_q     (fb_div),
      .n_q     (out_div_code),
      .ssc_q   (spread_en),
      .upd_q   (cfg_update)
   );

   cfg_range_chk #(.M_W(M_W), .M_LO(M_LO), .M_HI(M_HI)) range_i (
      .m  (fb_div),
      .bad(fb_div_bad)
   );
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
   parameter int             M_W   = 9,
   parameter int             N_W   = 2,
   parameter logic [N_W-1:0] N_RST = 'b01,
   parameter logic [N_W-1:0] N_PAR = 'b01
) (
   input logic           clk,
   input logic           rst_n,
   input logic           pl_hi_s,
   input logic           ld_s,
   input logic [M_W-1:0] fb_div,
   input logic [N_W-1:0] out_div_code,
   input logic           spread_en,
   input logic           cfg_update
);
   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (out_div_code == N_RST) && !spread_en && !cfg_update);

   assert_par_forces_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pl_hi_s |=> out_div_code == N_PAR);

   assert_serial_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pl_hi_s && !ld_s) |=> ($stable(fb_div) && $stable(out_div_code) && $stable(spread_en)));

   assert_update_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (cfg_update == ((fb_div != $past(fb_div)) ||
                                       (out_div_code != $past(out_div_code)) ||
                                       (spread_en != $past(spread_en)))));
endmodule

bind synth_cfg_loader cfg_loader_chk #(.M_W(M_W), .N_W(N_W), .N_RST(N_RST), .N_PAR(N_PAR)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .pl_hi_s     (pl_hi_s),
   .ld_s        (ld_s),
   .fb_div      (fb_div),
   .out_div_code(out_div_code),
   .spread_en   (spread_en),
   .cfg_update  (cfg_update)
);

// File: tb/synth_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module synth_cfg_loader_tb_top;
   localparam int SETTLE = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] fb_div_pin = 9'd200;
   logic       par_load_n = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_dat = 1'b0;
   logic       ser_ld = 1'b0;
   logic [8:0] fb_div;
   logic [1:0] out_div_code;
   logic       spread_en, fb_div_bad, cfg_update;

   int vectors = 0;
   int fails = 0;
   int upd_cnt = 0;
   bit done = 1'b0;

   logic [8:0]  em;
   logic [1:0]  en;
   logic        essc;
   logic [11:0] sr_m;

   always #4 clk = ~clk;

   synth_cfg_loader dut_i (
      .clk(clk), .rst_n(rst_n), .fb_div_pin(fb_div_pin), .par_load_n(par_load_n),
      .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
      .fb_div(fb_div), .out_div_code(out_div_code), .spread_en(spread_en),
      .fb_div_bad(fb_div_bad), .cfg_update(cfg_update)
   );

   always @(negedge clk) if (rst_n && cfg_update) upd_cnt++;

   function automatic bit exp_bad(input logic [8:0] m);
      return (m < 9'd125) || (m > 9'd350);
   endfunction

   task automatic tick(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_cfg(input string req);
      int act, exp;
      act = {spread_en, out_div_code, fb_div};
      exp = {essc, en, em};
      check(act == exp, req, act, exp);
      check(fb_div_bad == exp_bad(em), {req, "/R8 range flag"}, fb_div_bad, exp_bad(em));
   endtask

   task automatic chk_upd(input string req, input int base, input bit changed);
      check((upd_cnt - base) == int'(changed), {req, "/R9 update count"}, upd_cnt - base, int'(changed));
   endtask

   task automatic set_pins(input logic [8:0] v);
      fb_div_pin = v;
      if (!par_load_n) em = v;
      tick(SETTLE);
   endtask

   task automatic set_par(input bit v);
      par_load_n = v;
      if (!v) begin em = fb_div_pin; en = 2'b01; end
      tick(SETTLE);
   endtask

   task automatic sclk_pulse(input bit d);
      ser_dat = d;
      tick(SETTLE);
      ser_clk = 1'b1;
      if (par_load_n) begin
         sr_m = {sr_m[10:0], d};
         if (ser_ld) {essc, en, em} = sr_m;
      end
      tick(SETTLE);
      ser_clk = 1'b0;
      tick(SETTLE);
   endtask

   task automatic set_ld(input bit v);
      if (v && !ser_ld && par_load_n) {essc, en, em} = sr_m;
      ser_ld = v;
      tick(SETTLE);
   endtask

   task automatic shift_frame(input logic [13:0] f);
      for (int i = 13; i >= 0; i--) sclk_pulse(f[i]);
   endtask

   initial begin
      int seed;
      int base;
      logic [11:0] old;
      logic [8:0] mv;
      logic [13:0] fr;
      logic [8:0] edge_vals [4];
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      edge_vals[0] = 9'd124; edge_vals[1] = 9'd125;
      edge_vals[2] = 9'd350; edge_vals[3] = 9'd351;
      em = 9'd200; en = 2'b01; essc = 1'b0; sr_m = '0;

      tick(4);
      check(out_div_code == 2'b01 && !spread_en && !cfg_update && fb_div == 9'd200,
            "R1 reset state", {spread_en, out_div_code, fb_div}, {1'b0, 2'b01, 9'd200});
      rst_n = 1'b1;
      tick(SETTLE);
      chk_cfg("R1 after reset");

      for (int i = 0; i < 14; i++) begin
         old = {essc, en, em};
         base = upd_cnt;
         mv = (i < 4) ? edge_vals[i] : 9'($urandom);
         set_pins(mv);
         chk_cfg("R2 parallel follow");
         chk_upd("R2", base, old != {essc, en, em});
      end

      set_pins(9'd300);
      set_par(1'b1);
      base = upd_cnt;
      set_pins(9'd17);
      chk_cfg("R3 pins ignored after capture");
      chk_upd("R3", base, 1'b0);

      for (int i = 0; i < 24; i++) begin
         mv = (i < 4) ? edge_vals[i] : ((i == 4) ? 9'd0 : ((i == 5) ? 9'd511 : 9'($urandom)));
         fr = {2'($urandom), 3'($urandom), mv};
         old = {essc, en, em};
         base = upd_cnt;
         shift_frame(fr);
         chk_cfg("R5 hold while shifting");
         chk_upd("R5", base, 1'b0);
         set_ld(1'b1);
         chk_cfg("R4 frame load");
         chk_upd("R4", base, old != {essc, en, em});
         base = upd_cnt;
         set_ld(1'b0);
         chk_cfg("R5 hold on strobe fall");
         chk_upd("R5", base, 1'b0);
      end

      set_ld(1'b1);
      for (int i = 0; i < 20; i++) begin
         old = {essc, en, em};
         base = upd_cnt;
         sclk_pulse(1'($urandom));
         chk_cfg("R6 transparent shift");
         chk_upd("R6", base, old != {essc, en, em});
      end
      set_ld(1'b0);

      shift_frame({2'b00, 1'b1, 2'b11, 9'd250});
      set_ld(1'b1);
      set_ld(1'b0);
      chk_cfg("R4 directed frame");
      set_pins(9'd140);
      chk_cfg("R10 serial word persists");
      set_par(1'b0);
      chk_cfg("R10 parallel takes over");

      for (int i = 0; i < 4; i++) begin
         base = upd_cnt;
         shift_frame({2'b11, 3'($urandom), 9'($urandom)});
         set_ld(1'b1);
         set_ld(1'b0);
         chk_cfg("R7 serial ignored in parallel mode");
         chk_upd("R7", base, 1'b0);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         vectors++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule